// File: doc/BRIEF.md
# Sampling Period Generator with One-Shot Trim

This block divides a master clock into sampling periods and marks the start of each one with a single-cycle frame strobe. The nominal length of a period is twice the product of two programmable divider values, counted in master clocks. A signed trim value can stretch or shrink one period by its magnitude. This lets a downstream converter pull its sampling instant into line with an external bit stream without changing the nominal rate.

An adjustment is asked for through a two-bit command. The command can come from any of three sources: a field of the primary data word, a field of the secondary word, or two hardware pins. The block reads all of its control inputs only at the edge where the period counter wraps. At that edge it arbitrates between the three sources and works out the length of the period that begins there. It loads that length and reports it on `period_len`. An adjustment therefore lasts for exactly one period. The command must be presented again before a later wrap for the next period to be adjusted as well.

Top module: `sample_period_gen`

## Requirements
- R1: With no effective adjustment, a period lasts 2 × `div_a` × `div_b` master clocks, and rising frame strobes are exactly that many cycles apart.
- R2: While `rst` is high, `fsync` is 0 and `period_len` is 0. The first strobe appears at the first clock edge after reset is released. `fsync` is never high for two cycles in a row.
- R3: Command code 2'b01 (increase) adds the signed trim to the nominal length. A positive trim lengthens the period and a negative trim shortens it.
- R4: Command code 2'b10 (decrease) subtracts the signed trim from the nominal length. A positive trim shortens the period and a negative trim lengthens it.
- R5: When the trim is zero, every period has the nominal length, whatever command is given.
- R6: An adjustment applies only to the period that starts at the wrap edge where it was sampled. The following period is nominal unless a new command is present at its own wrap edge.
- R7: Codes 2'b00 and 2'b11 request no adjustment.
- R8: A source is active when its code is 01 or 10. The primary-word source wins over the secondary-word source, which wins over the pins.
- R9: The length loaded for any period is never below 4 master clocks. Smaller results, including a nominal length below 4, are raised to 4.
- R10: Divider, trim and command inputs are sampled only at the wrap edge. Changes between wrap edges have no effect on the running period.
- R11: `period_len` gives the length of the running period. It changes only at the edge that raises `fsync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| div_a | input | A_W | First divider value |
| div_b | input | B_W | Second divider value |
| trim | input | TRIM_W | Signed trim in master clocks (two's complement) |
| req_pri | input | 2 | Adjust command from the primary-word field |
| req_sec | input | 2 | Adjust command from the secondary-word field |
| req_pin | input | 2 | Adjust command from the hardware pins |
| fsync | output | 1 | One-cycle frame strobe at the start of each period |
| period_len | output | A_W+B_W+2 | Length of the running period in master clocks |

## Verification
The spacing check assumes that every loaded length is at least 4. This holds because of the clamp, whatever the inputs are. The zero-trim check assumes that the inputs present at a wrap edge are the ones that shaped the new period. The stimulus therefore changes dividers, trim and commands only in the cycle after a strobe. Where it makes a deliberate change in the middle of a period, it undoes that change within three cycles, so the next wrap edge, which is at least four cycles away, always sees the intended values. Divider products are kept small, so every run of periods finishes well inside the cycle budget.

// File: rtl/spg_pkg.sv
package spg_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_UP   = 2'b01,
    CMD_DOWN = 2'b10,
    CMD_BOTH = 2'b11
  } adj_cmd_e;

  localparam int MIN_LEN = 4;

  function automatic logic cmd_active(input logic [1:0] c);
    return (c == CMD_UP) || (c == CMD_DOWN);
  endfunction
endpackage

// File: rtl/spg_req_select.sv
module spg_req_select #(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0][1:0] req_in,
  output spg_pkg::adj_cmd_e    cmd
);
  import spg_pkg::*;

  logic [NSRC-1:0] active;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_act
      assign active[g] = cmd_active(req_in[g]);
    end
  endgenerate

  // index 0 has highest priority: walk from lowest to highest, overriding
  always_comb begin
    cmd = CMD_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (active[i]) cmd = adj_cmd_e'(req_in[i]);
    end
  end
endmodule

// File: rtl/spg_len_calc.sv
module spg_len_calc #(
  parameter int A_W    = 8,
  parameter int B_W    = 8,
  parameter int TRIM_W = 6,
  localparam int LEN_W = A_W + B_W + 2,
  localparam int SW    = LEN_W + 2
) (
  input  logic [A_W-1:0]           div_a,
  input  logic [B_W-1:0]           div_b,
  input  logic signed [TRIM_W-1:0] trim,
  input  spg_pkg::adj_cmd_e        cmd,
  output logic [LEN_W-1:0]         len
);
  import spg_pkg::*;

  localparam logic signed [SW-1:0] MIN_S = SW'(MIN_LEN);

  logic [A_W+B_W-1:0]     prod;
  logic [LEN_W-1:0]       nominal;
  logic signed [SW-1:0]   trim_x;
  logic signed [SW-1:0]   delta;
  logic signed [SW-1:0]   sum;

  always_comb begin
    prod    = {{B_W{1'b0}}, div_a} * {{A_W{1'b0}}, div_b};
    nominal = {1'b0, prod, 1'b0};
    trim_x  = {{(SW-TRIM_W){trim[TRIM_W-1]}}, trim};
    case (cmd)
      CMD_UP:   delta = trim_x;
      CMD_DOWN: delta = -trim_x;
      default:  delta = '0;
    endcase
    sum = $signed({2'b00, nominal}) + delta;
    if (sum < MIN_S) len = LEN_W'(MIN_LEN);
    else             len = sum[LEN_W-1:0];
  end
endmodule

// File: rtl/spg_counter.sv
module spg_counter #(
  parameter int LEN_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] next_len,
  output logic             wrap,
  output logic             fsync,
  output logic [LEN_W-1:0] period_len
);
  logic [LEN_W-1:0] cnt;

  assign wrap = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      fsync      <= 1'b0;
      period_len <= '0;
    end else if (wrap) begin
      cnt        <= next_len - LEN_W'(1);
      fsync      <= 1'b1;
      period_len <= next_len;
    end else begin
      cnt        <= cnt - LEN_W'(1);
      fsync      <= 1'b0;
    end
  end
endmodule

// File: rtl/sample_period_gen.sv
module sample_period_gen #(
  parameter int A_W    = 8,
  parameter int B_W    = 8,
  parameter int TRIM_W = 6,
  localparam int LEN_W = A_W + B_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [A_W-1:0]           div_a,
  input  logic [B_W-1:0]           div_b,
  input  logic signed [TRIM_W-1:0] trim,
  input  logic [1:0]               req_pri,
  input  logic [1:0]               req_sec,
  input  logic [1:0]               req_pin,
  output logic                     fsync,
  output logic [LEN_W-1:0]         period_len
);
  import spg_pkg::*;

  localparam int NSRC = 3;

  logic [NSRC-1:0][1:0] req_all;
  adj_cmd_e             cmd;
  logic [LEN_W-1:0]     next_len;
  logic                 wrap;

  assign req_all = {req_pin, req_sec, req_pri};

  spg_req_select #(.NSRC(NSRC)) u_sel (
    .req_in (req_all),
    .cmd    (cmd)
  );

  spg_len_calc #(.A_W(A_W), .B_W(B_W), .TRIM_W(TRIM_W)) u_calc (
    .div_a (div_a),
    .div_b (div_b),
    .trim  (trim),
    .cmd   (cmd),
    .len   (next_len)
  );

  spg_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .next_len   (next_len),
    .wrap       (wrap),
    .fsync      (fsync),
    .period_len (period_len)
  );
endmodule

// File: rtl/sample_period_gen_chk.sv
module sample_period_gen_chk #(
  parameter int A_W    = 8,
  parameter int B_W    = 8,
  parameter int TRIM_W = 6,
  localparam int LEN_W = A_W + B_W + 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic [A_W-1:0]           div_a,
  input logic [B_W-1:0]           div_b,
  input logic signed [TRIM_W-1:0] trim,
  input logic                     fsync,
  input logic [LEN_W-1:0]         period_len
);
  logic [LEN_W-1:0]  gap;
  logic              seen;
  logic [A_W-1:0]    a_q;
  logic [B_W-1:0]    b_q;
  logic [TRIM_W-1:0] trim_q;
  logic [LEN_W-1:0]  raw_nom;
  logic [LEN_W-1:0]  exp_nom;

  always_ff @(posedge clk) begin
    a_q    <= div_a;
    b_q    <= div_b;
    trim_q <= trim;
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (fsync) begin
      gap  <= LEN_W'(1);
      seen <= 1'b1;
    end else begin
      gap  <= gap + LEN_W'(1);
    end
  end

  always_comb begin
    raw_nom = LEN_W'(a_q) * LEN_W'(b_q) * LEN_W'(2);
    exp_nom = (raw_nom < LEN_W'(4)) ? LEN_W'(4) : raw_nom;
  end

  // R1
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    fsync && seen |-> gap == $past(period_len));

  // R2
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    fsync |=> !fsync);

  // R9
  min_len_chk: assert property (@(posedge clk) disable iff (rst)
    fsync |-> period_len >= LEN_W'(4));

  // R11
  len_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fsync |-> $stable(period_len));

  // R5
  zero_trim_chk: assert property (@(posedge clk) disable iff (rst)
    fsync && trim_q == '0 |-> period_len == exp_nom);
endmodule

bind sample_period_gen sample_period_gen_chk #(
  .A_W(A_W), .B_W(B_W), .TRIM_W(TRIM_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .div_a      (div_a),
  .div_b      (div_b),
  .trim       (trim),
  .fsync      (fsync),
  .period_len (period_len)
);

// File: tb/sample_period_gen_tb.sv
module sample_period_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int A_W = 8;
  localparam int B_W = 8;
  localparam int TRIM_W = 6;
  localparam int LEN_W = A_W + B_W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [A_W-1:0] div_a = 8'd3;
  logic [B_W-1:0] div_b = 8'd2;
  logic signed [TRIM_W-1:0] trim = 6'sd5;
  logic [1:0] req_pri = 2'b00;
  logic [1:0] req_sec = 2'b00;
  logic [1:0] req_pin = 2'b00;
  logic fsync;
  logic [LEN_W-1:0] period_len;

  int checks = 0;
  int errors = 0;
  int q_len[$];
  string q_tag[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_period_gen #(.A_W(A_W), .B_W(B_W), .TRIM_W(TRIM_W)) u_dut (
    .clk(clk), .rst(rst), .div_a(div_a), .div_b(div_b), .trim(trim),
    .req_pri(req_pri), .req_sec(req_sec), .req_pin(req_pin),
    .fsync(fsync), .period_len(period_len)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected length from the requirements
  function automatic int model(input int a, input int b, input int t,
                               input logic [1:0] p, input logic [1:0] s, input logic [1:0] h);
    logic [1:0] c;
    int l;
    c = 2'b00;
    if (h == 2'b01 || h == 2'b10) c = h;
    if (s == 2'b01 || s == 2'b10) c = s;
    if (p == 2'b01 || p == 2'b10) c = p;
    l = 2 * a * b;
    if (c == 2'b01) l = l + t;
    else if (c == 2'b10) l = l - t;
    if (l < 4) l = 4;
    return l;
  endfunction

  task automatic apply(input int a, input int b, input int t, input logic [1:0] p,
                       input logic [1:0] s, input logic [1:0] h, input string tag,
                       input bit glitch);
    while (!fsync) @(negedge clk);
    div_a = a[A_W-1:0]; div_b = b[B_W-1:0]; trim = t[TRIM_W-1:0];
    req_pri = p; req_sec = s; req_pin = h;
    q_len.push_back(model(a, b, t, p, s, h));
    q_tag.push_back(tag);
    @(negedge clk);
    if (glitch) begin
      @(negedge clk);
      div_a = 8'd9; trim = 6'sd20; req_pri = 2'b01;
      @(negedge clk);
      div_a = a[A_W-1:0]; trim = t[TRIM_W-1:0]; req_pri = p;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: pop expected lengths at each strobe and check spacing
  int gap = 0;
  int prev_len = 0;
  bit have_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (fsync) begin
        if (have_prev) check(gap == prev_len, "R1 strobe spacing", gap, prev_len);
        if (q_len.size() > 0) begin
          int e;
          string tg;
          e = q_len.pop_front();
          tg = q_tag.pop_front();
          check(int'(period_len) == e, tg, int'(period_len), e);
        end
        gap = 1;
        prev_len = int'(period_len);
        have_prev = 1'b1;
      end else begin
        gap++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    q_len.push_back(12);
    q_tag.push_back("R1 nominal first period");
    repeat (3) @(negedge clk);
    check(fsync == 1'b0, "R2 reset fsync", int'(fsync), 0);
    check(period_len == '0, "R2 reset period_len", int'(period_len), 0);
    rst = 1'b0;
    @(negedge clk);
    check(fsync == 1'b1, "R2 first strobe", int'(fsync), 1);
    apply(3, 2,   5, 2'b01, 2'b00, 2'b00, "R3 increase positive trim", 0);
    apply(3, 2,   5, 2'b00, 2'b00, 2'b00, "R6 back to nominal", 0);
    apply(3, 2,   5, 2'b10, 2'b00, 2'b00, "R4 decrease positive trim", 0);
    apply(3, 2,  -5, 2'b01, 2'b00, 2'b00, "R3 increase negative trim", 0);
    apply(3, 2,  -5, 2'b10, 2'b00, 2'b00, "R4 decrease negative trim", 0);
    apply(3, 2,   0, 2'b01, 2'b00, 2'b00, "R5 zero trim increase", 0);
    apply(3, 2,   0, 2'b10, 2'b01, 2'b00, "R5 zero trim decrease", 0);
    apply(3, 2,   5, 2'b11, 2'b00, 2'b00, "R7 code 11 ignored", 0);
    apply(3, 2,   5, 2'b00, 2'b01, 2'b00, "R8 secondary source", 0);
    apply(3, 2,   5, 2'b00, 2'b00, 2'b10, "R8 pin source", 0);
    apply(3, 2,   5, 2'b10, 2'b01, 2'b01, "R8 primary wins", 0);
    apply(3, 2,   5, 2'b11, 2'b10, 2'b01, "R8 inactive primary skipped", 0);
    apply(1, 2,   5, 2'b10, 2'b00, 2'b00, "R9 clamp after trim", 0);
    apply(1, 1,   0, 2'b00, 2'b00, 2'b00, "R9 clamp nominal", 0);
    apply(2, 2, -31, 2'b01, 2'b00, 2'b00, "R9 clamp negative trim", 0);
    apply(3, 2,   5, 2'b00, 2'b00, 2'b00, "R10 mid-period changes ignored", 1);
    apply(20, 10, 31, 2'b01, 2'b00, 2'b00, "R3 large period", 0);
    apply(3, 2,   5, 2'b00, 2'b00, 2'b00, "R6 nominal after large", 0);
    apply(3, 2,   5, 2'b00, 2'b00, 2'b00, "R11 final period", 0);
    while (q_len.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule